// File: doc/BRIEF.md
# Six-Master Programmable Priority Bus Arbiter

This block decides which of six bus masters owns a shared on-chip bus. Each master has a two-bit priority, and the requester with the highest value wins. The masters are an instruction-fetch unit (ID 0), a data cache (ID 1), an external bus master (ID 2), a bus bridge (ID 3), a descriptor-driven memory-access unit (ID 4) and a DMA engine (ID 5). Each master works out its priority in its own way:

- The data cache supplies its own upper priority bit. Only its lower bit is held in configuration.
- The external master has two programmed fields. A hold select signal chooses which one applies.
- The DMA engine has one request line and one programmed priority per channel. It competes at the highest priority among the channels that are currently requesting.

When the top requesters share the same priority value, a tie-break rule chooses among them. That rule is either a programmable fixed ranking of IDs or a round-robin rotation.

The priority fields are captured into configuration registers when a load strobe is high. Before the first load, those registers hold their reset values. The tie-break mode and the ranking are sampled live.

The grant is one-hot and registered. Once issued, a grant stays with its owner for as long as that owner keeps requesting.

Top module: `prio_bus_arbiter`

## Requirements
- R1: Among requesting masters, the grant goes to one whose effective priority is the highest; 2'b11 is highest and 2'b00 lowest.
- R2: After reset, no grant is active and the round-robin pointer behaves as if ID 5 was granted last. The captured priorities are 2'b11 for the bridge (ID 3) and 2'b10 for every other field, which includes the stored data-cache low bit of 0.
- R3: The priority fields are captured only in a cycle where `cfg_load_i` is high. A change on those inputs without a load has no effect on arbitration.
- R4: The effective priority of the data cache (ID 1) is {`dcache_prio_hi_i`, captured low bit`}`. The upper bit is used live, every cycle.
- R5: The effective priority of the external master (ID 2) is the captured field B when `ext_hold_sel_i` is 1, and the captured field A when it is 0.
- R6: The DMA master requests whenever any bit of `dma_req_i` is high. Its effective priority is the maximum captured priority among the requesting channels. Channel c uses bits [2c+1:2c] of `dma_prio_i`.
- R7: With `tie_mode_i` = 0, ties are broken by `tie_rank_i`. Bits [3p+2:3p] hold the master ID at rank position p, and position 0 wins first.
- R8: With `tie_mode_i` = 1, ties are broken round-robin. The scan starts at the ID after the last one granted and wraps from 5 to 0. The pointer moves only when a new grant is issued.
- R9: The grant is registered and at most one bit is high. It changes at the clock edge after the requests it answers. It is held while its owner keeps requesting, even if a higher-priority request arrives. When the owner drops its request, a new winner can be granted at that same edge.
- R10: With no requests, no grant is asserted at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_load_i | input | 1 | Capture strobe for all priority fields |
| ifetch_prio_i | input | 2 | Priority of ID 0 |
| dcache_prio_lo_i | input | 1 | Programmable low priority bit of ID 1 |
| dcache_prio_hi_i | input | 1 | Live high priority bit of ID 1, driven by cache logic |
| ext_prio_a_i | input | 2 | ID 2 priority used when hold select is 0 |
| ext_prio_b_i | input | 2 | ID 2 priority used when hold select is 1 |
| ext_hold_sel_i | input | 1 | Chooses between the two ID 2 fields |
| bridge_prio_i | input | 2 | Priority of ID 3 |
| desc_prio_i | input | 2 | Priority of ID 4 |
| dma_prio_i | input | 2*DMA_CH | Per-channel priorities of ID 5 |
| tie_mode_i | input | 1 | 0 = fixed ranking, 1 = round-robin |
| tie_rank_i | input | 18 | Six 3-bit IDs, rank position 0 in the low bits |
| req_i | input | 5 | Requests of IDs 0 to 4 |
| dma_req_i | input | DMA_CH | Per-channel DMA requests |
| gnt_o | output | 6 | One-hot registered grant, bit n = ID n |

## Verification
A wrong captured priority, or a wrong live bit, shows up as the wrong winner at the very next edge. However, it only shows when the faulty master competes against a rival that is close in priority. For that reason the bench sets up near-ties on purpose.

A corrupted round-robin pointer does not show in the first arbitration after the fault. It shows in the following sequence of tied grants, each one grant after the previous. The rotation is therefore followed across a full wrap.

A broken hold is seen as the grant jumping to a higher requester one edge after that requester appears.

// File: rtl/arb_pkg.sv
// Shared constants and types for the priority bus arbiter.
package arb_pkg;
    localparam int NUM_MASTERS = 6;
    localparam int PRIO_W      = 2;
    localparam int ID_W        = 3;

    typedef logic [PRIO_W-1:0] prio_t;

    localparam prio_t PRIO_DEFAULT    = 2'b10;
    localparam prio_t PRIO_BRIDGE_RST = 2'b11;

    localparam int M_IFETCH = 0;
    localparam int M_DCACHE = 1;
    localparam int M_EXT    = 2;
    localparam int M_BRIDGE = 3;
    localparam int M_DESC   = 4;
    localparam int M_DMA    = 5;
endpackage

// File: rtl/arb_cfg_regs.sv
// Configuration capture registers for all programmable priority fields.
// Assumes: load_i is a single-cycle or level strobe; fields are valid while it is high.
module arb_cfg_regs
    import arb_pkg::*;
#(
    parameter int DMA_CH = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load_i,
    input  prio_t                    ifetch_i,
    input  logic                     dcache_lo_i,
    input  prio_t                    ext_a_i,
    input  prio_t                    ext_b_i,
    input  prio_t                    bridge_i,
    input  prio_t                    desc_i,
    input  logic [DMA_CH*PRIO_W-1:0] dma_i,
    output prio_t                    ifetch_q,
    output logic                     dcache_lo_q,
    output prio_t                    ext_a_q,
    output prio_t                    ext_b_q,
    output prio_t                    bridge_q,
    output prio_t                    desc_q,
    output logic [DMA_CH*PRIO_W-1:0] dma_q
);
    localparam int DMA_BITS = DMA_CH * PRIO_W;

    // Capture every field on load; reset to the defined default priorities.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ifetch_q    <= PRIO_DEFAULT;
            dcache_lo_q <= PRIO_DEFAULT[0];
            ext_a_q     <= PRIO_DEFAULT;
            ext_b_q     <= PRIO_DEFAULT;
            bridge_q    <= PRIO_BRIDGE_RST;
            desc_q      <= PRIO_DEFAULT;
            dma_q       <= {DMA_CH{PRIO_DEFAULT}};
        end else if (load_i) begin
            ifetch_q    <= ifetch_i;
            dcache_lo_q <= dcache_lo_i;
            ext_a_q     <= ext_a_i;
            ext_b_q     <= ext_b_i;
            bridge_q    <= bridge_i;
            desc_q      <= desc_i;
            dma_q       <= dma_i;
        end
    end

    // R3: without a load strobe the captured priorities do not move.
    a_r3_no_load_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable({ifetch_q, dcache_lo_q, ext_a_q, ext_b_q, bridge_q, desc_q, dma_q}));

    // R3: a load makes the registers equal to the presented fields.
    a_r3_load_captures: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (dma_q == $past(dma_i[DMA_BITS-1:0])) && (bridge_q == $past(bridge_i)));
endmodule

// File: rtl/arb_eff_prio.sv
// Effective-priority resolution: applies the live data-cache bit, the
// external-master field select and the DMA channel maximum.
// Assumes: combinational only; inputs come from arb_cfg_regs and ports.
module arb_eff_prio
    import arb_pkg::*;
#(
    parameter int DMA_CH = 4
) (
    input  prio_t                         ifetch_q,
    input  logic                          dcache_lo_q,
    input  logic                          dcache_hi_i,
    input  prio_t                         ext_a_q,
    input  prio_t                         ext_b_q,
    input  logic                          ext_hold_sel_i,
    input  prio_t                         bridge_q,
    input  prio_t                         desc_q,
    input  logic [DMA_CH*PRIO_W-1:0]      dma_q,
    input  logic [DMA_CH-1:0]             dma_req_i,
    output logic [NUM_MASTERS*PRIO_W-1:0] eff_o,
    output logic                          dma_any_o
);
    prio_t dma_max;

    // Highest captured priority among requesting DMA channels.
    always_comb begin
        dma_max = '0;
        for (int c = 0; c < DMA_CH; c++) begin
            if (dma_req_i[c] && (dma_q[c*PRIO_W +: PRIO_W] > dma_max))
                dma_max = dma_q[c*PRIO_W +: PRIO_W];
        end
    end

    // Assemble the per-master effective priority vector.
    always_comb begin
        eff_o = '0;
        eff_o[M_IFETCH*PRIO_W +: PRIO_W] = ifetch_q;
        eff_o[M_DCACHE*PRIO_W +: PRIO_W] = {dcache_hi_i, dcache_lo_q};
        eff_o[M_EXT*PRIO_W    +: PRIO_W] = ext_hold_sel_i ? ext_b_q : ext_a_q;
        eff_o[M_BRIDGE*PRIO_W +: PRIO_W] = bridge_q;
        eff_o[M_DESC*PRIO_W   +: PRIO_W] = desc_q;
        eff_o[M_DMA*PRIO_W    +: PRIO_W] = dma_max;
    end

    assign dma_any_o = |dma_req_i;
endmodule

// File: rtl/arb_pick.sv
// Winner selection: finds the top priority among requesters, then breaks
// ties by fixed rank or round-robin after the last granted ID.
// Assumes: tie_rank_i is a permutation of IDs 0..5; last_id_i is below 6.
module arb_pick
    import arb_pkg::*;
(
    input  logic [NUM_MASTERS-1:0]        req_i,
    input  logic [NUM_MASTERS*PRIO_W-1:0] eff_i,
    input  logic                          tie_mode_i,
    input  logic [NUM_MASTERS*ID_W-1:0]   tie_rank_i,
    input  logic [ID_W-1:0]               last_id_i,
    output logic                          win_valid_o,
    output logic [ID_W-1:0]               win_id_o
);
    prio_t                  top;
    logic [NUM_MASTERS-1:0] cand;

    // Find the highest priority among the active requesters.
    always_comb begin
        top = '0;
        for (int i = 0; i < NUM_MASTERS; i++) begin
            if (req_i[i] && (eff_i[i*PRIO_W +: PRIO_W] > top))
                top = eff_i[i*PRIO_W +: PRIO_W];
        end
    end

    // Mark requesters sitting at the top priority.
    always_comb begin
        for (int i = 0; i < NUM_MASTERS; i++)
            cand[i] = req_i[i] && (eff_i[i*PRIO_W +: PRIO_W] == top);
    end

    // Break the tie by fixed ranking or by rotating scan.
    always_comb begin
        logic [ID_W-1:0] id;
        logic            found;
        found    = 1'b0;
        win_id_o = '0;
        if (!tie_mode_i) begin
            for (int p = 0; p < NUM_MASTERS; p++) begin
                id = tie_rank_i[p*ID_W +: ID_W];
                if (!found && (int'(id) < NUM_MASTERS) && cand[id]) begin
                    found    = 1'b1;
                    win_id_o = id;
                end
            end
        end else begin
            for (int k = 1; k <= NUM_MASTERS; k++) begin
                id = ID_W'((int'(last_id_i) + k) % NUM_MASTERS);
                if (!found && cand[id]) begin
                    found    = 1'b1;
                    win_id_o = id;
                end
            end
        end
        win_valid_o = found;
    end
endmodule

// File: rtl/prio_bus_arbiter.sv
// Top of the six-master programmable priority bus arbiter. Holds the
// registered one-hot grant and the round-robin pointer.
// Assumes: synchronous active-low reset; requests are held until granted.
module prio_bus_arbiter
    import arb_pkg::*;
#(
    parameter int DMA_CH = 4
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            cfg_load_i,
    input  logic [1:0]                      ifetch_prio_i,
    input  logic                            dcache_prio_lo_i,
    input  logic                            dcache_prio_hi_i,
    input  logic [1:0]                      ext_prio_a_i,
    input  logic [1:0]                      ext_prio_b_i,
    input  logic                            ext_hold_sel_i,
    input  logic [1:0]                      bridge_prio_i,
    input  logic [1:0]                      desc_prio_i,
    input  logic [DMA_CH*2-1:0]             dma_prio_i,
    input  logic                            tie_mode_i,
    input  logic [17:0]                     tie_rank_i,
    input  logic [4:0]                      req_i,
    input  logic [DMA_CH-1:0]               dma_req_i,
    output logic [5:0]                      gnt_o
);
    localparam logic [ID_W-1:0] LAST_RST = ID_W'(NUM_MASTERS - 1);

    prio_t                         ifetch_q, ext_a_q, ext_b_q, bridge_q, desc_q;
    logic                          dcache_lo_q;
    logic [DMA_CH*PRIO_W-1:0]      dma_q;
    logic [NUM_MASTERS*PRIO_W-1:0] eff;
    logic                          dma_any;
    logic [NUM_MASTERS-1:0]        req_vec;
    logic                          win_valid;
    logic [ID_W-1:0]               win_id;
    logic [NUM_MASTERS-1:0]        gnt_q;
    logic [ID_W-1:0]               last_q;
    logic                          holder_live;

    arb_cfg_regs #(.DMA_CH(DMA_CH)) u_cfg (
        .clk(clk), .rst_n(rst_n), .load_i(cfg_load_i),
        .ifetch_i(ifetch_prio_i), .dcache_lo_i(dcache_prio_lo_i),
        .ext_a_i(ext_prio_a_i), .ext_b_i(ext_prio_b_i),
        .bridge_i(bridge_prio_i), .desc_i(desc_prio_i), .dma_i(dma_prio_i),
        .ifetch_q(ifetch_q), .dcache_lo_q(dcache_lo_q),
        .ext_a_q(ext_a_q), .ext_b_q(ext_b_q),
        .bridge_q(bridge_q), .desc_q(desc_q), .dma_q(dma_q)
    );

    arb_eff_prio #(.DMA_CH(DMA_CH)) u_eff (
        .ifetch_q(ifetch_q), .dcache_lo_q(dcache_lo_q), .dcache_hi_i(dcache_prio_hi_i),
        .ext_a_q(ext_a_q), .ext_b_q(ext_b_q), .ext_hold_sel_i(ext_hold_sel_i),
        .bridge_q(bridge_q), .desc_q(desc_q), .dma_q(dma_q),
        .dma_req_i(dma_req_i), .eff_o(eff), .dma_any_o(dma_any)
    );

    assign req_vec = {dma_any, req_i};

    arb_pick u_pick (
        .req_i(req_vec), .eff_i(eff), .tie_mode_i(tie_mode_i),
        .tie_rank_i(tie_rank_i), .last_id_i(last_q),
        .win_valid_o(win_valid), .win_id_o(win_id)
    );

    assign holder_live = |(gnt_q & req_vec);

    // Keep the grant while its owner requests; otherwise issue the new winner.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gnt_q  <= '0;
            last_q <= LAST_RST;
        end else if (!holder_live) begin
            gnt_q <= win_valid ? (NUM_MASTERS'(1) << win_id) : '0;
            if (win_valid)
                last_q <= win_id;
        end
    end

    assign gnt_o = gnt_q;

    // R9: never more than one grant.
    a_r9_onehot: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(gnt_q));

    // R9: an owner that keeps requesting keeps the grant.
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        holder_live |=> (gnt_q == $past(gnt_q)));

    // R9: a grant only goes to a master that requested in the prior cycle.
    a_r9_requested: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_q != '0) && !$stable(gnt_q) |-> ((gnt_q & $past(req_vec)) != '0));

    // R10: no requests, no grant at the next edge.
    a_r10_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vec == '0) |=> (gnt_q == '0));

    // R8: the pointer is frozen while the grant is held.
    a_r8_ptr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        holder_live |=> $stable(last_q));

    // R1: the chosen winner is at least as high as every requester.
    for (genvar i = 0; i < NUM_MASTERS; i++) begin : g_top_check
        a_r1_winner_highest: assert property (@(posedge clk) disable iff (!rst_n)
            (win_valid && req_vec[i]) |->
            (eff[i*PRIO_W +: PRIO_W] <= eff[int'(win_id)*PRIO_W +: PRIO_W]));
    end

    // R6: the DMA master priority is not below any requesting channel.
    for (genvar c = 0; c < DMA_CH; c++) begin : g_dma_check
        a_r6_dma_max: assert property (@(posedge clk) disable iff (!rst_n)
            dma_req_i[c] |-> (eff[M_DMA*PRIO_W +: PRIO_W] >= dma_q[c*PRIO_W +: PRIO_W]));
    end
endmodule

// File: tb/prio_bus_arbiter_test.sv
`timescale 1ns/1ps
module prio_bus_arbiter_test;
    typedef struct {
        logic [5:0] exp;
        string      tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_load_i;
    logic [1:0]  ifetch_prio_i, ext_prio_a_i, ext_prio_b_i, bridge_prio_i, desc_prio_i;
    logic        dcache_prio_lo_i, dcache_prio_hi_i, ext_hold_sel_i, tie_mode_i;
    logic [7:0]  dma_prio_i;
    logic [17:0] tie_rank_i;
    logic [4:0]  req_i;
    logic [3:0]  dma_req_i;
    logic [5:0]  gnt_o;

    int    checks = 0;
    int    fails  = 0;
    bit    done   = 1'b0;
    item_t sb[$];

    localparam logic [17:0] RANK_ID  = {3'd5, 3'd4, 3'd3, 3'd2, 3'd1, 3'd0};
    localparam logic [17:0] RANK_REV = {3'd0, 3'd1, 3'd2, 3'd3, 3'd4, 3'd5};

    always #10 clk = ~clk;

    prio_bus_arbiter uut (
        .clk(clk), .rst_n(rst_n), .cfg_load_i(cfg_load_i),
        .ifetch_prio_i(ifetch_prio_i), .dcache_prio_lo_i(dcache_prio_lo_i),
        .dcache_prio_hi_i(dcache_prio_hi_i), .ext_prio_a_i(ext_prio_a_i),
        .ext_prio_b_i(ext_prio_b_i), .ext_hold_sel_i(ext_hold_sel_i),
        .bridge_prio_i(bridge_prio_i), .desc_prio_i(desc_prio_i),
        .dma_prio_i(dma_prio_i), .tie_mode_i(tie_mode_i), .tie_rank_i(tie_rank_i),
        .req_i(req_i), .dma_req_i(dma_req_i), .gnt_o(gnt_o)
    );

    // Driver: apply one cycle of requests and queue the grant expected after the edge.
    task automatic step(input logic [4:0] r, input logic [3:0] d,
                        input logic [5:0] e, input string tag, input bit load = 1'b0);
        @(negedge clk);
        req_i      = r;
        dma_req_i  = d;
        cfg_load_i = load;
        sb.push_back('{exp: e, tag: tag});
    endtask

    // Monitor: a quarter period after each edge, compare the grant with the queue head.
    always @(posedge clk) begin
        #5;
        if (sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            checks++;
            if (gnt_o !== it.exp) begin
                fails++;
                $display("FAIL %s: gnt actual %b expected %b", it.tag, gnt_o, it.exp);
            end
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(20 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; cfg_load_i = 1'b0; req_i = '0; dma_req_i = '0;
        ifetch_prio_i = 2'b00; dcache_prio_lo_i = 1'b0; dcache_prio_hi_i = 1'b1;
        ext_prio_a_i = 2'b00; ext_prio_b_i = 2'b00; ext_hold_sel_i = 1'b0;
        bridge_prio_i = 2'b00; desc_prio_i = 2'b00; dma_prio_i = '0;
        tie_mode_i = 1'b0; tie_rank_i = RANK_ID;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        checks++;
        if (gnt_o !== 6'b0) begin
            fails++;
            $display("FAIL R2 reset grant: actual %b expected %b", gnt_o, 6'b0);
        end

        // R10 / R2: idle after reset
        step(5'b00000, 4'b0000, 6'b000000, "R10 idle after reset");
        // R2: reset priorities -> bridge at 11 beats everyone at 10
        step(5'b11111, 4'b0001, 6'b001000, "R2 reset bridge priority");
        step(5'b00000, 4'b0000, 6'b000000, "R10 idle");
        // R7: ties at 10, identity rank then reversed rank
        step(5'b00111, 4'b0000, 6'b000001, "R7 identity rank");
        step(5'b00000, 4'b0000, 6'b000000, "R10 idle");
        tie_rank_i = RANK_REV;
        step(5'b00111, 4'b0000, 6'b000100, "R7 reversed rank");
        step(5'b00000, 4'b0000, 6'b000000, "R10 idle");
        // R9: hold against a higher requester, then hand-over at the same edge
        step(5'b00001, 4'b0000, 6'b000001, "R9 first grant");
        step(5'b01001, 4'b0000, 6'b000001, "R9 hold despite higher");
        step(5'b01000, 4'b0000, 6'b001000, "R9 hand-over");
        step(5'b00000, 4'b0000, 6'b000000, "R10 idle");
        // R3: change bridge field without a load -> still 11, bridge wins
        bridge_prio_i = 2'b00; ifetch_prio_i = 2'b11;
        step(5'b01001, 4'b0000, 6'b001000, "R3 no load no effect");
        step(5'b00000, 4'b0000, 6'b000000, "R10 idle");
        // R3: load new fields
        dcache_prio_lo_i = 1'b1; ext_prio_a_i = 2'b00; ext_prio_b_i = 2'b01;
        bridge_prio_i = 2'b01; desc_prio_i = 2'b00; dma_prio_i = {2'b10, 2'b11, 2'b01, 2'b00};
        step(5'b00000, 4'b0000, 6'b000000, "R3 load cycle", 1'b1);
        step(5'b01001, 4'b0000, 6'b000001, "R3 loaded ifetch over bridge");
        step(5'b00000, 4'b0000, 6'b000000, "R10 idle");
        // R4: live high bit of the data cache
        dcache_prio_hi_i = 1'b1;
        step(5'b01010, 4'b0000, 6'b000010, "R4 hi bit set");
        step(5'b00000, 4'b0000, 6'b000000, "R10 idle");
        dcache_prio_hi_i = 1'b0;
        step(5'b01010, 4'b0000, 6'b001000, "R4 hi bit clear ties");
        step(5'b00000, 4'b0000, 6'b000000, "R10 idle");
        // R5: hold select for the external master
        step(5'b10100, 4'b0000, 6'b010000, "R5 field A");
        step(5'b00000, 4'b0000, 6'b000000, "R10 idle");
        ext_hold_sel_i = 1'b1;
        step(5'b10100, 4'b0000, 6'b000100, "R5 field B");
        step(5'b00000, 4'b0000, 6'b000000, "R10 idle");
        // R6: DMA channel maximum
        step(5'b01000, 4'b0001, 6'b001000, "R6 low channel loses");
        step(5'b00000, 4'b0000, 6'b000000, "R10 idle");
        step(5'b01000, 4'b0101, 6'b100000, "R6 max channel wins");
        step(5'b00000, 4'b0000, 6'b000000, "R10 idle");
        step(5'b01000, 4'b0010, 6'b100000, "R6 tie rank with channel");
        step(5'b00000, 4'b0000, 6'b000000, "R10 idle");
        // R8: round-robin over IDs 1,2,3,5 all at 01, last granted was 5
        tie_mode_i = 1'b1;
        step(5'b01110, 4'b0010, 6'b000010, "R8 rr after 5");
        step(5'b00000, 4'b0000, 6'b000000, "R8 idle keeps pointer");
        step(5'b01110, 4'b0010, 6'b000100, "R8 rr after 1");
        step(5'b00000, 4'b0000, 6'b000000, "R10 idle");
        step(5'b01110, 4'b0010, 6'b001000, "R8 rr after 2");
        step(5'b00000, 4'b0000, 6'b000000, "R10 idle");
        step(5'b01110, 4'b0010, 6'b100000, "R8 rr after 3");
        step(5'b00000, 4'b0000, 6'b000000, "R10 idle");
        step(5'b01110, 4'b0010, 6'b000010, "R8 rr wrap");
        step(5'b00000, 4'b0000, 6'b000000, "R10 idle");
        // R1: higher priority beats round-robin order
        step(5'b01111, 4'b0010, 6'b000001, "R1 top priority wins");
        step(5'b00000, 4'b0000, 6'b000000, "R10 idle");

        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule